// File: doc/BRIEF.md
# Interrupt Source Routing Register File

This block collects a set of hardware interrupt sources and merges each one with a software-raised request bit. It then sends every source either to the normal interrupt path or to the fast interrupt path, as a per-source select bit chooses. Sources on the normal path are gated by an enable mask. The qualified normal-path pending vector goes to a separate priority unit. The fast-path sources bypass the enable mask and are ORed into a single fast interrupt line.

Software reaches the block through a word-addressed register port. Enables and software requests each have a write-one-to-set word and a write-one-to-clear word, so one source can change without a read-modify-write. Read-only views show the raw, normal-path and fast-path status, and a small identification block is read-only. The vector slot storage and the nesting state live in the priority unit. This block only decodes their address windows and forwards those accesses on a side port.

The register port has a plain strobe and no back-pressure. The block accepts an access on every cycle that `acc_en` is high. Read data returns exactly one cycle later, qualified by `rd_valid`. The forwarded side port is also plain and needs no reply except `fwd_rdata`, which is sampled in the same cycle as the forwarded strobe.

Top module: `irq_route_regs`

## Requirements
- R1: The raw status of source i is the hardware input i, registered once on the clock, ORed with software bit i. A change on `src_lvl` shows in raw status after one rising edge.
- R2: `irq_pend` equals raw AND enable AND NOT select. A read of word 0 (byte 0x000) returns the same value.
- R3: Fast status equals raw AND select, whatever the enable mask holds. It is read at word 1 (0x004). `fiq_o` is high exactly when any fast status bit is set.
- R4: A write to word 4 (0x010) sets every enable bit where the data is 1. A write to word 5 (0x014) clears every enable bit where the data is 1. Zero bits leave their enable bits unchanged. A read of word 4 returns the enable mask, and a read of word 5 returns zero.
- R5: Word 6 (0x018) and word 7 (0x01C) set and clear the software request bits in the same way. A read of word 6 returns the software bits, and a read of word 7 returns zero.
- R6: Word 3 (0x00C) is the select register and is a plain read/write register (1 = fast path). Word 8 (0x020) stores data bit 0 only and reads it back in bit 0.
- R7: Reads of byte 0xFE0 + 4k, for k = 0..7, return 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R8: Writes to word 0, word 1, word 2 (raw, 0x008) and the identification words change no state.
- R9: Accesses to 0x100–0x13F raise `fwd_en` with region 0, and accesses to 0x200–0x23F raise it with region 1. In both windows `fwd_idx` is the word number within the window. Word 12 (0x030) forwards as region 2 and word 13 (0x034) as region 3, both with index 0. A forwarded read returns `fwd_rdata`.
- R10: Reads of any other offset return zero, and writes to them change no state.
- R11: After reset the enable, software, select and protection registers are zero, `irq_pend` is zero and `fiq_o` is low.
- R12: A read issued while `acc_en` is high with `acc_we` low gives `rd_valid` high with its data on the next cycle. `rd_valid` is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NSRC | Hardware interrupt levels |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset; the two low bits are ignored |
| acc_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| irq_pend | output | NSRC | Qualified normal-path pending vector |
| fiq_o | output | 1 | Fast interrupt line |
| fwd_en | output | 1 | Forwarded access strobe to the priority unit |
| fwd_we | output | 1 | Forwarded write flag |
| fwd_region | output | 2 | 0 slot addresses, 1 slot controls, 2 current vector, 3 default vector |
| fwd_idx | output | 4 | Word index inside the region |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_rdata | input | DATA_W | Read data from the priority unit |

## Verification
The hardest case to reach from the ports is a source that is raised in hardware and in software at once while it is routed to the fast path with its enable clear. Here the normal path must stay silent, the fast line must rise, and clearing only one of the two request origins must change nothing. The stimulus builds this state on purpose: it enables nothing, selects the fast path, and then layers the hardware and software requests in turn. Random runs then mix set/clear writes with wide random masks and random source levels, so that all of these combinations also arise in bulk.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned W_IRQST  = 0;
  localparam int unsigned W_FIQST  = 1;
  localparam int unsigned W_RAW    = 2;
  localparam int unsigned W_SEL    = 3;
  localparam int unsigned W_ENSET  = 4;
  localparam int unsigned W_ENCLR  = 5;
  localparam int unsigned W_SSET   = 6;
  localparam int unsigned W_SCLR   = 7;
  localparam int unsigned W_PROT   = 8;
  localparam int unsigned W_CURVEC = 12;
  localparam int unsigned W_DEFVEC = 13;

  typedef enum logic [3:0] {
    T_IRQST, T_FIQST, T_RAW, T_SEL, T_ENSET, T_ENCLR,
    T_SSET, T_SCLR, T_PROT, T_ID, T_FWD, T_NONE
  } tgt_e;

  typedef enum logic [1:0] {
    RG_SLOTADDR = 2'd0,
    RG_SLOTCTRL = 2'd1,
    RG_CURVEC   = 2'd2,
    RG_DEFVEC   = 2'd3
  } region_e;
endpackage

// File: rtl/src_sample.sv
module src_sample #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned STAGES = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] d,
  output logic [NSRC-1:0] q
);
  logic [NSRC-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ic_decode.sv
module ic_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output region_e           region,
  output logic [3:0]        idx,
  output logic [2:0]        id_idx
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;

  assign word   = addr[ADDR_W-1:2];
  assign id_idx = word[2:0];

  always_comb begin
    tgt    = T_NONE;
    region = RG_SLOTADDR;
    idx    = '0;
    if (word >= WORD_W'(10'h3F8)) begin
      tgt = T_ID;
    end else if (word >= WORD_W'(10'h040) && word < WORD_W'(10'h050)) begin
      tgt    = T_FWD;
      region = RG_SLOTADDR;
      idx    = word[3:0];
    end else if (word >= WORD_W'(10'h080) && word < WORD_W'(10'h090)) begin
      tgt    = T_FWD;
      region = RG_SLOTCTRL;
      idx    = word[3:0];
    end else begin
      unique case (word)
        WORD_W'(W_IRQST):  tgt = T_IRQST;
        WORD_W'(W_FIQST):  tgt = T_FIQST;
        WORD_W'(W_RAW):    tgt = T_RAW;
        WORD_W'(W_SEL):    tgt = T_SEL;
        WORD_W'(W_ENSET):  tgt = T_ENSET;
        WORD_W'(W_ENCLR):  tgt = T_ENCLR;
        WORD_W'(W_SSET):   tgt = T_SSET;
        WORD_W'(W_SCLR):   tgt = T_SCLR;
        WORD_W'(W_PROT):   tgt = T_PROT;
        WORD_W'(W_CURVEC): begin tgt = T_FWD; region = RG_CURVEC; end
        WORD_W'(W_DEFVEC): begin tgt = T_FWD; region = RG_DEFVEC; end
        default:           tgt = T_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ic_regbank.sv
module ic_regbank
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   soft_q,
  output logic [NSRC-1:0]   sel_q,
  output logic              prot_q
);
  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      soft_q <= '0;
      sel_q  <= '0;
      prot_q <= 1'b0;
    end else if (wr) begin
      case (tgt)
        T_ENSET: en_q   <= en_q | wbits;
        T_ENCLR: en_q   <= en_q & ~wbits;
        T_SSET:  soft_q <= soft_q | wbits;
        T_SCLR:  soft_q <= soft_q & ~wbits;
        T_SEL:   sel_q  <= wbits;
        T_PROT:  prot_q <= wdata[0];
        default: ;
      endcase
    end
  end

  // R4
  enset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && tgt == T_ENSET) |=> ((en_q & $past(wbits)) == $past(wbits)));
  // R4
  enclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && tgt == T_ENCLR) |=> ((en_q & $past(wbits)) == '0));
  // R5
  softclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && tgt == T_SCLR) |=> ((soft_q & $past(wbits)) == '0));
  // R8
  ro_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (tgt == T_IRQST || tgt == T_FIQST || tgt == T_RAW || tgt == T_ID))
    |=> ($stable(en_q) && $stable(soft_q) && $stable(sel_q) && $stable(prot_q)));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [NSRC-1:0]   irq_pend,
  output logic              fiq_o,
  output logic              fwd_en,
  output logic              fwd_we,
  output logic [1:0]        fwd_region,
  output logic [3:0]        fwd_idx,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic [DATA_W-1:0] fwd_rdata
);
  logic [NSRC-1:0] src_q, en_q, soft_q, sel_q, raw, fiq_st;
  logic            prot_q;
  tgt_e            tgt;
  region_e         region;
  logic [2:0]      id_idx;
  logic [DATA_W-1:0] rmux;

  src_sample #(.NSRC(NSRC), .STAGES(STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .d(src_lvl), .q(src_q));

  ic_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(acc_addr), .tgt(tgt), .region(region), .idx(fwd_idx), .id_idx(id_idx));

  ic_regbank #(.NSRC(NSRC), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(acc_en && acc_we), .tgt(tgt),
    .wdata(acc_wdata), .en_q(en_q), .soft_q(soft_q), .sel_q(sel_q), .prot_q(prot_q));

  assign raw      = src_q | soft_q;
  assign irq_pend = raw & en_q & ~sel_q;
  assign fiq_st   = raw & sel_q;
  assign fiq_o    = |fiq_st;

  assign fwd_en     = acc_en && (tgt == T_FWD);
  assign fwd_we     = acc_we;
  assign fwd_region = region;
  assign fwd_wdata  = acc_wdata;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h90;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    rmux = '0;
    case (tgt)
      T_IRQST: rmux = DATA_W'(irq_pend);
      T_FIQST: rmux = DATA_W'(fiq_st);
      T_RAW:   rmux = DATA_W'(raw);
      T_SEL:   rmux = DATA_W'(sel_q);
      T_ENSET: rmux = DATA_W'(en_q);
      T_SSET:  rmux = DATA_W'(soft_q);
      T_PROT:  rmux = DATA_W'(prot_q);
      T_ID:    rmux = DATA_W'(id_byte(id_idx));
      T_FWD:   rmux = fwd_rdata;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_en && !acc_we;
      if (acc_en && !acc_we) rd_data <= rmux;
    end
  end

  // R2
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & ~en_q) == '0) && ((irq_pend & sel_q) == '0));
  // R3
  fiq_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((sel_q & (src_q | soft_q)) != '0));
  // R12
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(acc_en && !acc_we));
  // R9
  fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en |-> acc_en);
endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int NSRC = 32;
  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_lvl = '0;
  logic acc_en = 0, acc_we = 0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic rd_valid, fiq_o, fwd_en, fwd_we;
  logic [31:0] rd_data, fwd_wdata, fwd_rdata;
  logic [NSRC-1:0] irq_pend;
  logic [1:0] fwd_region;
  logic [3:0] fwd_idx;
  int checks = 0, fails = 0;

  logic [31:0] m_en = 0, m_soft = 0, m_sel = 0, m_src = 0;
  logic m_prot = 0;

  always #5 clk = ~clk;

  assign fwd_rdata = 32'hA500_0000 | (32'(fwd_region) << 8) | 32'(fwd_idx);

  irq_route_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = a;
    @(negedge clk);
    acc_en = 0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk); src_lvl = s; m_src = s;
    @(negedge clk);
  endtask

  function automatic logic [31:0] e_raw();  return m_src | m_soft; endfunction
  function automatic logic [31:0] e_irq();  return e_raw() & m_en & ~m_sel; endfunction
  function automatic logic [31:0] e_fiq();  return e_raw() & m_sel; endfunction

  task automatic check_all(input string tag);
    logic [31:0] d; logic v;
    chk({tag, " R2 irq_pend"}, irq_pend, e_irq());
    chk({tag, " R3 fiq_o"}, 32'(fiq_o), 32'(e_fiq() != 0));
    rd(12'h000, d, v); chk({tag, " R2 word0"}, d, e_irq());
    rd(12'h004, d, v); chk({tag, " R3 word1"}, d, e_fiq());
    rd(12'h008, d, v); chk({tag, " R1 raw"}, d, e_raw());
    rd(12'h010, d, v); chk({tag, " R4 enable"}, d, m_en);
    rd(12'h018, d, v); chk({tag, " R5 soft"}, d, m_soft);
    rd(12'h00C, d, v); chk({tag, " R6 select"}, d, m_sel);
  endtask

  localparam logic [7:0] IDB [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d; logic v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq_pend", irq_pend, 0);
    chk("R11 fiq_o", 32'(fiq_o), 0);
    chk("R12 idle rd_valid", 32'(rd_valid), 0);
    check_all("R11");

    // R1 sample delay: one edge
    @(negedge clk); src_lvl = 32'h0000_0F0F; m_src = src_lvl;
    chk("R1 before edge", u0.irq_pend, 0);
    @(negedge clk);
    rd(12'h008, d, v);
    chk("R1 raw after edge", d, 32'h0000_0F0F);
    chk("R12 rd_valid", 32'(v), 1);
    @(negedge clk);
    chk("R12 rd_valid drops", 32'(rd_valid), 0);

    // R4 set/clear
    wr(12'h010, 32'h0000_00FF); m_en |= 32'hFF;
    wr(12'h014, 32'h0000_000F); m_en &= ~32'hF;
    rd(12'h014, d, v); chk("R4 clear word reads zero", d, 0);
    check_all("R4");

    // Corner: fast path, enable clear, hw + sw overlapped
    wr(12'h014, 32'hFFFF_FFFF); m_en = 0;
    wr(12'h00C, 32'h8000_0000); m_sel = 32'h8000_0000;
    set_src(32'h8000_0000);
    wr(12'h018, 32'h8000_0000); m_soft |= 32'h8000_0000;
    check_all("R3 corner");
    set_src(32'h0);
    chk("R3 soft holds fiq", 32'(fiq_o), 1);
    wr(12'h01C, 32'h8000_0000); m_soft = 0;
    chk("R5 soft cleared fiq low", 32'(fiq_o), 0);
    rd(12'h01C, d, v); chk("R5 clear word reads zero", d, 0);

    // R6 protection bit 0 only
    wr(12'h020, 32'hFFFF_FFFE);
    rd(12'h020, d, v); chk("R6 prot bit0 clear", d, 0);
    wr(12'h020, 32'h0000_0003);
    rd(12'h020, d, v); chk("R6 prot bit0 only", d, 1);

    // R7 ID bytes
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4*k), d, v); chk("R7 id byte", d, 32'(IDB[k]));
    end

    // R8 writes to read-only words ignored
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF); wr(12'hFE4, 32'hFFFF_FFFF);
    check_all("R8");
    rd(12'hFE4, d, v); chk("R8 id unchanged", d, 32'h11);

    // R9 forwarding
    @(negedge clk); acc_en = 1; acc_we = 1; acc_addr = 12'h134; acc_wdata = 32'h55;
    #1;
    chk("R9 fwd_en slot addr", 32'(fwd_en), 1);
    chk("R9 region/idx", {fwd_region, fwd_idx}, {2'd0, 4'd13});
    chk("R9 fwd_we", 32'(fwd_we), 1);
    chk("R9 fwd_wdata", fwd_wdata, 32'h55);
    @(negedge clk); acc_en = 0; acc_we = 0;
    rd(12'h208, d, v); chk("R9 slot ctrl read", d, 32'hA500_0102);
    rd(12'h030, d, v); chk("R9 current vector", d, 32'hA500_0200);
    rd(12'h034, d, v); chk("R9 default vector", d, 32'hA500_0300);
    @(negedge clk); acc_en = 1; acc_we = 0; acc_addr = 12'h010; #1;
    chk("R9 no fwd on local", 32'(fwd_en), 0);
    @(negedge clk); acc_en = 0;

    // R10 unmapped
    foreach (IDB[k]) begin end
    rd(12'h024, d, v); chk("R10 unmapped 0x024", d, 0);
    rd(12'h140, d, v); chk("R10 unmapped 0x140", d, 0);
    rd(12'h800, d, v); chk("R10 unmapped 0x800", d, 0);
    wr(12'h028, 32'hFFFF_FFFF); wr(12'h240, 32'hFFFF_FFFF);
    check_all("R10");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [31:0] m;
      m = $urandom();
      case ($urandom_range(0, 6))
        0: begin wr(12'h010, m); m_en |= m; end
        1: begin wr(12'h014, m); m_en &= ~m; end
        2: begin wr(12'h018, m); m_soft |= m; end
        3: begin wr(12'h01C, m); m_soft &= ~m; end
        4: begin wr(12'h00C, m); m_sel = m; end
        default: set_src(m);
      endcase
      check_all("rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule